// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast oscillator-side clock by a programmable total ratio and, in a second clock domain, divides a reference clock by a separate programmable ratio. The fast path is built the way a synthesizer feedback chain is built. A prescaler stretches its count by one cycle while a swallow counter is still non-zero. A main counter counts prescaler periods. Together they give a total ratio of M×N + A, where M is the prescaler's base modulus. The prescaler is plain synchronous logic clocked by the fast clock.

Each path produces a one-cycle pulse per completed divide period. A phase comparator downstream uses these pulses. Ratio inputs are treated as already-latched configuration words. The block samples them only at a period boundary, so a period that has started always completes with the settings it started with. If a word would give an illegal ratio, the block sets a per-path error flag and keeps running on the last legal settings.

Top module: `pulse_swallow_divider`

## Requirements
- R1: On the fast clock, consecutive `fb_pulse` pulses are exactly M×N + A fast-clock cycles apart. A is the swallow count, N is the main count and M is the active base modulus.
- R2: When `low_mod_sel` is 1, M is `PRE_LO` and the prescaler divides by PRE_LO or PRE_LO+1. When it is 0, M is `PRE_HI`.
- R3: A swallow count of 0 gives exactly M×N. Any A from 0 up to N−1 is accepted.
- R4: `fb_pulse` and `rf_pulse` are each high for exactly one cycle of their own clock per period.
- R5: Swallow count, main count and modulus select are taken only at the end of a feedback period. A change made mid-period leaves that period's length unchanged and applies to the next one.
- R6: A main count below 5, or a swallow count not below the main count, is illegal. At the boundary where such a word is sampled, `fb_cfg_err` goes to 1 and the previous swallow count, main count and select stay in force. The flag returns to 0 at the next boundary that samples a legal word.
- R7: On the reference clock, consecutive `rf_pulse` pulses are exactly R reference cycles apart.
- R8: The reference ratio is taken only at the end of a reference period. A mid-period change applies from the next period.
- R9: A reference ratio below 5 is illegal. At the sampling boundary `rf_cfg_err` goes to 1 and the previous ratio is kept. The flag clears at the next legal sample.
- R10: While `rst_n` is low both pulses and both error flags are 0. After reset the dividers run with the reset configuration from the parameters `RST_A`, `RST_N`, `RST_SEL` and `RST_R`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Oscillator-side clock being divided |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| swallow_cnt | input | A_W | Swallow count A |
| main_cnt | input | N_W | Main count N |
| low_mod_sel | input | 1 | 1 selects PRE_LO/PRE_LO+1, 0 selects PRE_HI/PRE_HI+1 |
| ref_ratio | input | R_W | Reference ratio R |
| fb_pulse | output | 1 | One-cycle comparison pulse per feedback period |
| rf_pulse | output | 1 | One-cycle reference pulse per reference period |
| fb_cfg_err | output | 1 | Last sampled feedback word was illegal |
| rf_cfg_err | output | 1 | Last sampled reference ratio was illegal |

## Verification
The bench builds the block with `PRE_LO` = 4 and `PRE_HI` = 8. It keeps the default counter widths and the reset configuration A=0, N=5, select 0, R=5. The small moduli keep every feedback period under a hundred cycles. Within that budget the bench covers the shortest main count, the largest legal swallow count for a given N, both modulus selects, mid-period reconfiguration and the illegal-word hold. Each period length is measured by counting edges between pulses.

// File: rtl/sw_div_pkg.sv
// Package: shared limits and legality helpers for the pulse-swallow divider.
// Assumes callers zero-extend counter words to 32 bits.
package sw_div_pkg;

    localparam int unsigned MIN_COUNT = 5;

    // True when a main or reference count is large enough to be used
    function automatic logic count_ok(input int unsigned v);
        return v >= MIN_COUNT;
    endfunction

    // True when the swallow count fits inside the main count
    function automatic logic swallow_ok(input int unsigned a, input int unsigned n);
        return (n >= MIN_COUNT) && (a < n);
    endfunction

endpackage

// File: rtl/sw_prescaler.sv
// Module: dual-modulus prescaler modelled as a synchronous down-counter.
// It emits a one-cycle tick on the last cycle of each prescaler period.
// On that tick it reloads for the next period, whose length is the selected
// modulus plus one when stretch_next is set.
// Assumes: 2 <= PRE_LO <= PRE_HI and RST_LEN in [PRE_LO, PRE_HI+1].
module sw_prescaler #(
    parameter int unsigned PRE_LO  = 32,
    parameter int unsigned PRE_HI  = 64,
    parameter int unsigned RST_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lo_next,
    input  logic stretch_next,
    output logic tick
);
    localparam int unsigned CW = $clog2(PRE_HI + 2);
    localparam logic [CW-1:0] LO_M1  = CW'(PRE_LO - 1);
    localparam logic [CW-1:0] HI_M1  = CW'(PRE_HI - 1);
    localparam logic [CW-1:0] RST_M1 = CW'(RST_LEN - 1);

    logic [CW-1:0] pre_cnt;
    logic [CW-1:0] reload_val;

    assign tick = (pre_cnt == '0);

    // Length-minus-one of the next prescaler period
    always_comb begin
        reload_val = (sel_lo_next ? LO_M1 : HI_M1) + CW'(stretch_next);
    end

    // Count down and reload at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= RST_M1;
        else if (tick) pre_cnt <= reload_val;
        else           pre_cnt <= pre_cnt - CW'(1);
    end

    // R2: the counter never exceeds the longest legal period
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= CW'(PRE_HI));

    // R2: a reload for the low modulus never exceeds PRE_LO
    a_r2_lo_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel_lo_next) |=> (pre_cnt <= CW'(PRE_LO)));

endmodule

// File: rtl/sw_count_ctrl.sv
// Module: swallow and main counters that steer the prescaler.
// It holds the active configuration, samples new words only at the end of a
// feedback period, rejects illegal words and drives the comparison pulse.
// Assumes: RST_A < RST_N and RST_N >= 5; A_W <= N_W.
module sw_count_ctrl
    import sw_div_pkg::*;
#(
    parameter int unsigned A_W     = 7,
    parameter int unsigned N_W     = 11,
    parameter int unsigned RST_A   = 0,
    parameter int unsigned RST_N   = 5,
    parameter bit          RST_SEL = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [A_W-1:0] cfg_a,
    input  logic [N_W-1:0] cfg_n,
    input  logic           cfg_sel,
    output logic           sel_lo_next,
    output logic           stretch_next,
    output logic           fb_pulse,
    output logic           fb_err
);
    logic [A_W-1:0] a_act, a_left, a_nxt, a_use;
    logic [N_W-1:0] n_act, n_left, n_nxt, n_use;
    logic           sel_act, sel_use;
    logic           period_end, cfg_ok;

    assign period_end = tick && (n_left == N_W'(1));
    assign cfg_ok     = swallow_ok(32'(cfg_a), 32'(cfg_n));

    // Pick the configuration that the next period will use
    always_comb begin
        if (period_end && cfg_ok) begin
            a_use = cfg_a; n_use = cfg_n; sel_use = cfg_sel;
        end else begin
            a_use = a_act; n_use = n_act; sel_use = sel_act;
        end
    end

    // Next counter state: reload at period end, step on each prescaler tick
    always_comb begin
        if (period_end) begin
            a_nxt = a_use;
            n_nxt = n_use;
        end else if (tick) begin
            a_nxt = (a_left == '0) ? '0 : a_left - A_W'(1);
            n_nxt = n_left - N_W'(1);
        end else begin
            a_nxt = a_left;
            n_nxt = n_left;
        end
    end

    assign stretch_next = (a_nxt != '0);
    assign sel_lo_next  = period_end ? sel_use : sel_act;

    // Active configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_act <= A_W'(RST_A); n_act <= N_W'(RST_N); sel_act <= RST_SEL;
        end else if (period_end) begin
            a_act <= a_use; n_act <= n_use; sel_act <= sel_use;
        end
    end

    // Remaining swallow and main counts in the current period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_left <= A_W'(RST_A); n_left <= N_W'(RST_N);
        end else begin
            a_left <= a_nxt; n_left <= n_nxt;
        end
    end

    // Comparison pulse and sticky-until-next-sample error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_pulse <= 1'b0; fb_err <= 1'b0;
        end else begin
            fb_pulse <= period_end;
            if (period_end) fb_err <= !cfg_ok;
        end
    end

    // R4: a comparison pulse lasts one cycle
    a_r4_fb_single: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R1: stretched prescaler periods always fit inside the main count
    a_r1_swallow_within: assert property (@(posedge clk) disable iff (!rst_n)
        N_W'(a_left) < n_left);

    // R5: the active configuration only moves at a period boundary
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(n_act) && $stable(a_act) && $stable(sel_act)));

    // R6: the configuration in force is always legal
    a_r6_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act >= N_W'(MIN_COUNT)) && (N_W'(a_act) < n_act));

endmodule

// File: rtl/sw_ref_div.sv
// Module: programmable reference divider.
// A down-counter of period R produces one pulse per period. The ratio is
// sampled only at wrap, and a ratio below the minimum is rejected with a flag.
// Assumes: RST_R >= 5.
module sw_ref_div
    import sw_div_pkg::*;
#(
    parameter int unsigned R_W   = 14,
    parameter int unsigned RST_R = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] cfg_r,
    output logic           rf_pulse,
    output logic           rf_err
);
    logic [R_W-1:0] r_act, r_cnt;
    logic           wrap, r_ok;

    assign wrap = (r_cnt == '0);
    assign r_ok = count_ok(32'(cfg_r));

    // Ratio in force and the count toward the next wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_act <= R_W'(RST_R);
            r_cnt <= R_W'(RST_R - 1);
        end else if (wrap) begin
            if (r_ok) begin
                r_act <= cfg_r;
                r_cnt <= cfg_r - R_W'(1);
            end else begin
                r_cnt <= r_act - R_W'(1);
            end
        end else begin
            r_cnt <= r_cnt - R_W'(1);
        end
    end

    // Reference pulse and error flag updated at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_pulse <= 1'b0; rf_err <= 1'b0;
        end else begin
            rf_pulse <= wrap;
            if (wrap) rf_err <= !r_ok;
        end
    end

    // R7: a reference pulse lasts one cycle
    a_r7_rf_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pulse |=> !rf_pulse);

    // R9: the ratio in force is legal and bounds the running count
    a_r9_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (r_act >= R_W'(MIN_COUNT)) && (r_cnt < r_act));

    // R8: the ratio in force only changes at a wrap
    a_r8_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(r_act));

endmodule

// File: rtl/pulse_swallow_divider.sv
// Module: top of the pulse-swallow divider.
// The fast path is a dual-modulus prescaler steered by swallow and main
// counters, with total ratio M*N+A. The reference path is a separate
// programmable divider. Each path runs on its own clock, and rst_n is
// synchronous to both.
// Assumes: rst_n is held low for several cycles of both clocks.
module pulse_swallow_divider #(
    parameter int unsigned PRE_LO  = 32,
    parameter int unsigned PRE_HI  = 64,
    parameter int unsigned A_W     = 7,
    parameter int unsigned N_W     = 11,
    parameter int unsigned R_W     = 14,
    parameter int unsigned RST_A   = 0,
    parameter int unsigned RST_N   = 5,
    parameter bit          RST_SEL = 1'b0,
    parameter int unsigned RST_R   = 5
) (
    input  logic           fast_clk,
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_cnt,
    input  logic [N_W-1:0] main_cnt,
    input  logic           low_mod_sel,
    input  logic [R_W-1:0] ref_ratio,
    output logic           fb_pulse,
    output logic           rf_pulse,
    output logic           fb_cfg_err,
    output logic           rf_cfg_err
);
    localparam int unsigned RST_LEN = (RST_SEL ? PRE_LO : PRE_HI) + ((RST_A != 0) ? 1 : 0);

    logic pre_tick, sel_lo_next, stretch_next;

    sw_prescaler #(
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI),
        .RST_LEN(RST_LEN)
    ) u_pre (
        .clk         (fast_clk),
        .rst_n       (rst_n),
        .sel_lo_next (sel_lo_next),
        .stretch_next(stretch_next),
        .tick        (pre_tick)
    );

    sw_count_ctrl #(
        .A_W    (A_W),
        .N_W    (N_W),
        .RST_A  (RST_A),
        .RST_N  (RST_N),
        .RST_SEL(RST_SEL)
    ) u_ctrl (
        .clk         (fast_clk),
        .rst_n       (rst_n),
        .tick        (pre_tick),
        .cfg_a       (swallow_cnt),
        .cfg_n       (main_cnt),
        .cfg_sel     (low_mod_sel),
        .sel_lo_next (sel_lo_next),
        .stretch_next(stretch_next),
        .fb_pulse    (fb_pulse),
        .fb_err      (fb_cfg_err)
    );

    sw_ref_div #(
        .R_W  (R_W),
        .RST_R(RST_R)
    ) u_ref (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .cfg_r   (ref_ratio),
        .rf_pulse(rf_pulse),
        .rf_err  (rf_cfg_err)
    );

endmodule

// File: tb/pulse_swallow_divider_tb_top.sv
module pulse_swallow_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 14;
    localparam int LO = 4;
    localparam int HI = 8;

    logic        fast_clk = 1'b0;
    logic        ref_clk  = 1'b0;
    logic        rst_n    = 1'b0;
    logic [6:0]  swallow_cnt = 7'd0;
    logic [10:0] main_cnt    = 11'd5;
    logic        low_mod_sel = 1'b0;
    logic [13:0] ref_ratio   = 14'd5;
    logic        fb_pulse, rf_pulse, fb_cfg_err, rf_cfg_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) fast_clk = ~fast_clk;
    always #(REF_PERIOD/2) ref_clk  = ~ref_clk;

    pulse_swallow_divider #(.PRE_LO(LO), .PRE_HI(HI)) dut_i (
        .fast_clk(fast_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .low_mod_sel(low_mod_sel),
        .ref_ratio(ref_ratio), .fb_pulse(fb_pulse), .rf_pulse(rf_pulse),
        .fb_cfg_err(fb_cfg_err), .rf_cfg_err(rf_cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Step past any current pulse, then stop on the next feedback pulse
    task automatic wait_fb();
        @(negedge fast_clk);
        while (!fb_pulse) @(negedge fast_clk);
    endtask

    task automatic wait_rf();
        @(negedge ref_clk);
        while (!rf_pulse) @(negedge ref_clk);
    endtask

    // Cycles from the current pulse to the next one
    task automatic measure_fb(output int n);
        n = 0;
        do begin @(negedge fast_clk); n++; end while (!fb_pulse);
    endtask

    task automatic measure_rf(output int n);
        n = 0;
        do begin @(negedge ref_clk); n++; end while (!rf_pulse);
    endtask

    task automatic set_fb(input bit sel, input int a, input int n);
        low_mod_sel = sel; swallow_cnt = 7'(a); main_cnt = 11'(n);
    endtask

    // R10: outputs low in reset, then the reset configuration runs
    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (6) @(negedge ref_clk);
        check("R10 fb_pulse in reset", int'(fb_pulse), 0);
        check("R10 rf_pulse in reset", int'(rf_pulse), 0);
        check("R10 fb_cfg_err in reset", int'(fb_cfg_err), 0);
        check("R10 rf_cfg_err in reset", int'(rf_cfg_err), 0);
        @(negedge fast_clk);
        rst_n = 1'b1;
        wait_fb();
        measure_fb(n);
        check("R10 default feedback period", n, HI*5);
    endtask

    // R1 R2 R3: program a ratio and measure one full period
    task automatic t_ratio(input string req, input bit sel, input int a, input int n);
        int got;
        set_fb(sel, a, n);
        wait_fb();
        check({req, " err clear"}, int'(fb_cfg_err), 0);
        measure_fb(got);
        check(req, got, (sel ? LO : HI) * n + a);
    endtask

    // R4: pulse is one cycle wide
    task automatic t_width();
        wait_fb();
        @(negedge fast_clk);
        check("R4 fb_pulse one cycle", int'(fb_pulse), 0);
        wait_rf();
        @(negedge ref_clk);
        check("R4 rf_pulse one cycle", int'(rf_pulse), 0);
    endtask

    // R5: a mid-period change waits for the boundary
    task automatic t_midchange();
        int got;
        set_fb(1'b0, 0, 5);
        wait_fb();
        repeat (3) @(negedge fast_clk);
        set_fb(1'b1, 2, 9);
        got = 3;
        do begin @(negedge fast_clk); got++; end while (!fb_pulse);
        check("R5 period unchanged by mid-period write", got, HI*5);
        measure_fb(got);
        check("R5 new ratio from next period", got, LO*9 + 2);
    endtask

    // R6: illegal words flag and keep the previous configuration
    task automatic t_illegal();
        int got;
        set_fb(1'b0, 0, 4);
        wait_fb();
        check("R6 err on N below 5", int'(fb_cfg_err), 1);
        measure_fb(got);
        check("R6 previous ratio kept (N low)", got, LO*9 + 2);
        set_fb(1'b0, 9, 9);
        wait_fb();
        check("R6 err on A equal N", int'(fb_cfg_err), 1);
        measure_fb(got);
        check("R6 previous ratio kept (A>=N)", got, LO*9 + 2);
        set_fb(1'b1, 1, 5);
        wait_fb();
        check("R6 err cleared by legal word", int'(fb_cfg_err), 0);
        measure_fb(got);
        check("R6 legal ratio after recovery", got, LO*5 + 1);
    endtask

    // R7: reference period equals R
    task automatic t_ref(input int r);
        int got;
        ref_ratio = 14'(r);
        wait_rf();
        check("R7 rf err clear", int'(rf_cfg_err), 0);
        measure_rf(got);
        check("R7 reference period", got, r);
    endtask

    // R8 R9: mid-period change and illegal ratio on the reference path
    task automatic t_ref_rules();
        int got;
        ref_ratio = 14'd7;
        wait_rf();
        repeat (2) @(negedge ref_clk);
        ref_ratio = 14'd11;
        got = 2;
        do begin @(negedge ref_clk); got++; end while (!rf_pulse);
        check("R8 reference period unchanged mid-period", got, 7);
        measure_rf(got);
        check("R8 new reference ratio next period", got, 11);
        ref_ratio = 14'd4;
        wait_rf();
        check("R9 rf err on R below 5", int'(rf_cfg_err), 1);
        measure_rf(got);
        check("R9 previous reference ratio kept", got, 11);
        ref_ratio = 14'd6;
        wait_rf();
        check("R9 rf err cleared", int'(rf_cfg_err), 0);
        measure_rf(got);
        check("R9 legal reference ratio", got, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ratio("R1 high modulus with swallow", 1'b0, 3, 7);
        t_ratio("R2 low modulus select", 1'b1, 0, 6);
        t_ratio("R3 max swallow A=N-1", 1'b1, 5, 6);
        t_ratio("R3 zero swallow at N=5", 1'b0, 0, 5);
        t_width();
        t_midchange();
        t_illegal();
        t_ref(13);
        t_ref(5);
        t_ref_rules();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule